// File: doc/BRIEF.md
# Pipeline Forwarding and Stall Controller

This block is the hazard control for a five-stage in-order integer pipeline. It has no clock and no registers. The pipeline feeds it the source register numbers of the instructions now in decode and in execute. It also feeds it the destination number, write enable and load flag held in each of the three later pipeline registers. From these inputs the block works out the selects for the two ALU operand bypass muxes and the select for the store-data bypass into the memory stage. It also raises three hold controls when a load is followed at once by an instruction that needs the loaded value.

For each ALU operand, the bypass picks the youngest producer in flight. A result that is one instruction ahead comes from the execute/memory register. A result that is two instructions ahead comes from the memory/writeback register. A result that is three or more instructions ahead needs no bypass: the register file writes early in the cycle and reads late, so it returns the new value in time. A load in the memory stage has no data yet, so it never feeds an ALU operand.

A store that copies the result of the load just ahead of it does not stall. Its data is patched in the memory stage from the load's result in the writeback register. Any other use of a loaded register by the next instruction stalls the pipeline for one cycle. During that cycle the PC and the fetch/decode register hold, and a bubble goes into the decode/execute register. The load itself moves on, so the stall condition is gone on the next cycle.

Top module: `hz_ctrl`

## Requirements
- R1: An ALU operand select is 2'b10 (take the execute/memory result) when the execute/memory stage writes, is not a load, and its destination equals that operand's source register.
- R2: When R1 does not apply, an operand select is 2'b01 (take the memory/writeback result) when the memory/writeback stage writes and its destination equals that operand's source register.
- R3: When both later stages write the register an operand needs, the operand select is 2'b10, so the younger producer wins.
- R4: When neither later stage matches, an operand select is 2'b00, meaning the register file value is used.
- R5: Register 0 never causes a bypass and never causes a stall, whatever the stage fields hold.
- R6: A stage whose write enable is low causes no bypass and no stall.
- R7: `pc_hold`, `ifid_hold` and `idex_bubble` are all 1 when the decode/execute stage holds a writing load whose destination equals a source that the decode instruction marks as used.
- R8: When the decode instruction is a store and the load's destination matches only its store-data source (rs2), there is no stall. A match on its address source (rs1) still stalls.
- R9: `st_data_fwd` is 1 exactly when the memory stage holds a store and the writeback stage holds a writing load whose destination is nonzero and equals the store's data register.
- R10: The three hold outputs always carry the same value.
- R11: A source whose used flag is low never causes a stall.
- R12: A load in the execute/memory stage is never an ALU bypass source. An older matching producer in memory/writeback may still be selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | Decode instruction first source register |
| id_rs2 | input | 5 | Decode instruction second source register |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| id_is_store | input | 1 | Decode instruction is a store (rs2 is store data) |
| ex_rs1 | input | 5 | Execute instruction first source register |
| ex_rs2 | input | 5 | Execute instruction second source register |
| idex_rd | input | 5 | Destination held in decode/execute register |
| idex_we | input | 1 | Register write enable in decode/execute register |
| idex_mem_rd | input | 1 | Decode/execute register holds a load |
| exmem_rd | input | 5 | Destination held in execute/memory register |
| exmem_we | input | 1 | Register write enable in execute/memory register |
| exmem_mem_rd | input | 1 | Execute/memory register holds a load |
| exmem_is_store | input | 1 | Execute/memory register holds a store |
| exmem_rs2 | input | 5 | Store-data source register of the memory-stage instruction |
| memwb_rd | input | 5 | Destination held in memory/writeback register |
| memwb_we | input | 1 | Register write enable in memory/writeback register |
| memwb_mem_rd | input | 1 | Memory/writeback register holds a load |
| fwd_a | output | 2 | First ALU operand select (00 file, 01 writeback, 10 memory) |
| fwd_b | output | 2 | Second ALU operand select (same encoding) |
| st_data_fwd | output | 1 | Replace store data in memory stage with writeback result |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| idex_bubble | output | 1 | Clear control fields written into decode/execute register |

## Verification
The hardest case to reach is the one where several conditions meet at once. A load in the execute/memory stage and an older writer in memory/writeback both name the operand's register, and a decode store at the same moment reads the load's destination only as store data. Picking register numbers uniformly at random from 32 values almost never lines up three matching fields. So the random stimulus draws every register field from a pool of four numbers that includes register 0, and it sets the flags with even odds. Directed vectors then build each overlap on purpose, along with the register 0 and write-disabled variants.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } opnd_sel_e;
endpackage

// File: rtl/hz_opnd_sel.sv
module hz_opnd_sel
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic              mem_is_load,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  output opnd_sel_e         sel
);
  logic mem_hit, wb_hit;

  // loads in the memory stage carry an address, not a result
  assign mem_hit = mem_we && !mem_is_load && (mem_rd != '0) && (mem_rd == src);
  assign wb_hit  = wb_we && (wb_rd != '0) && (wb_rd == src);

  always_comb begin
    if (mem_hit)     sel = SEL_MEM;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs1,
  input  logic [REG_AW-1:0] rs2,
  input  logic              rs1_used,
  input  logic              rs2_used,
  input  logic              is_store,
  input  logic [REG_AW-1:0] ld_rd,
  input  logic              ld_we,
  input  logic              ld_flag,
  output logic              stall
);
  logic live_load, hit1, hit2;

  assign live_load = ld_flag && ld_we && (ld_rd != '0);
  assign hit1 = rs1_used && (rs1 == ld_rd);
  // store data is patched later in the memory stage; no stall needed
  assign hit2 = rs2_used && (rs2 == ld_rd) && !is_store;
  assign stall = live_load && (hit1 || hit2);
endmodule

// File: rtl/hz_store_byp.sv
module hz_store_byp #(
  parameter int REG_AW = 5
) (
  input  logic              st_valid,
  input  logic [REG_AW-1:0] st_src,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  input  logic              wb_is_load,
  output logic              use_wb
);
  assign use_wb = st_valid && wb_we && wb_is_load && (wb_rd != '0) && (wb_rd == st_src);
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_rs1_used,
  input  logic              id_rs2_used,
  input  logic              id_is_store,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] idex_rd,
  input  logic              idex_we,
  input  logic              idex_mem_rd,
  input  logic [REG_AW-1:0] exmem_rd,
  input  logic              exmem_we,
  input  logic              exmem_mem_rd,
  input  logic              exmem_is_store,
  input  logic [REG_AW-1:0] exmem_rs2,
  input  logic [REG_AW-1:0] memwb_rd,
  input  logic              memwb_we,
  input  logic              memwb_mem_rd,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              st_data_fwd,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              idex_bubble
);
  localparam int NUM_OPND = 2;

  logic [REG_AW-1:0] opnd_src [NUM_OPND];
  opnd_sel_e         opnd_sel [NUM_OPND];
  logic              lu_stall;

  assign opnd_src[0] = ex_rs1;
  assign opnd_src[1] = ex_rs2;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    hz_opnd_sel #(.REG_AW(REG_AW)) u_sel (
      .src        (opnd_src[g]),
      .mem_rd     (exmem_rd),
      .mem_we     (exmem_we),
      .mem_is_load(exmem_mem_rd),
      .wb_rd      (memwb_rd),
      .wb_we      (memwb_we),
      .sel        (opnd_sel[g])
    );
  end

  assign fwd_a = opnd_sel[0];
  assign fwd_b = opnd_sel[1];

  hz_load_use #(.REG_AW(REG_AW)) u_lu (
    .rs1     (id_rs1),
    .rs2     (id_rs2),
    .rs1_used(id_rs1_used),
    .rs2_used(id_rs2_used),
    .is_store(id_is_store),
    .ld_rd   (idex_rd),
    .ld_we   (idex_we),
    .ld_flag (idex_mem_rd),
    .stall   (lu_stall)
  );

  assign pc_hold     = lu_stall;
  assign ifid_hold   = lu_stall;
  assign idex_bubble = lu_stall;

  hz_store_byp #(.REG_AW(REG_AW)) u_stb (
    .st_valid  (exmem_is_store),
    .st_src    (exmem_rs2),
    .wb_rd     (memwb_rd),
    .wb_we     (memwb_we),
    .wb_is_load(memwb_mem_rd),
    .use_wb    (st_data_fwd)
  );
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] id_rs1,
  input logic [REG_AW-1:0] id_rs2,
  input logic              id_rs1_used,
  input logic              id_rs2_used,
  input logic              id_is_store,
  input logic [REG_AW-1:0] ex_rs1,
  input logic [REG_AW-1:0] idex_rd,
  input logic              idex_we,
  input logic              idex_mem_rd,
  input logic [REG_AW-1:0] exmem_rd,
  input logic              exmem_we,
  input logic              exmem_mem_rd,
  input logic [REG_AW-1:0] memwb_rd,
  input logic              memwb_we,
  input logic [1:0]        fwd_a,
  input logic              st_data_fwd,
  input logic              pc_hold,
  input logic              ifid_hold,
  input logic              idex_bubble
);
  always_comb begin
    p_mem_youngest_r3: assert (!(exmem_we && !exmem_mem_rd && exmem_rd != '0 &&
                                 exmem_rd == ex_rs1) || fwd_a == 2'b10)
      else $error("operand A skipped younger producer");
    p_no_load_src_r12: assert (!(exmem_mem_rd && !(memwb_we && memwb_rd == ex_rs1 &&
                                 memwb_rd != '0)) || fwd_a == 2'b00)
      else $error("memory-stage load used as ALU source");
    p_zero_reg_r5: assert (ex_rs1 != '0 || fwd_a == 2'b00)
      else $error("register 0 forwarded");
    p_holds_agree_r10: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble)
      else $error("hold outputs disagree");
    p_no_load_no_stall_r6: assert (idex_mem_rd && idex_we || !pc_hold)
      else $error("stall without a live load");
    p_store_copy_r8: assert (!(id_is_store && !id_rs1_used && id_rs2_used) || !pc_hold)
      else $error("store data match stalled");
    p_zero_no_stall_r5: assert (idex_rd != '0 || !idex_bubble)
      else $error("register 0 stalled");
    p_st_needs_wb_r9: assert (!st_data_fwd || (memwb_we && memwb_rd != '0))
      else $error("store bypass with no writer");
  end

  logic unused_ok;
  assign unused_ok = ^{id_rs1, id_rs2};
endmodule

bind hz_ctrl hz_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .id_rs1      (id_rs1),
  .id_rs2      (id_rs2),
  .id_rs1_used (id_rs1_used),
  .id_rs2_used (id_rs2_used),
  .id_is_store (id_is_store),
  .ex_rs1      (ex_rs1),
  .idex_rd     (idex_rd),
  .idex_we     (idex_we),
  .idex_mem_rd (idex_mem_rd),
  .exmem_rd    (exmem_rd),
  .exmem_we    (exmem_we),
  .exmem_mem_rd(exmem_mem_rd),
  .memwb_rd    (memwb_rd),
  .memwb_we    (memwb_we),
  .fwd_a       (fwd_a),
  .st_data_fwd (st_data_fwd),
  .pc_hold     (pc_hold),
  .ifid_hold   (ifid_hold),
  .idex_bubble (idex_bubble)
);

// File: tb/hz_ctrl_tb.sv
module hz_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
  logic [AW-1:0] idex_rd = '0, exmem_rd = '0, exmem_rs2 = '0, memwb_rd = '0;
  logic id_rs1_used = 0, id_rs2_used = 0, id_is_store = 0;
  logic idex_we = 0, idex_mem_rd = 0, exmem_we = 0, exmem_mem_rd = 0;
  logic exmem_is_store = 0, memwb_we = 0, memwb_mem_rd = 0;
  logic [1:0] fwd_a, fwd_b;
  logic st_data_fwd, pc_hold, ifid_hold, idex_bubble;

  int n_run = 0;
  int n_fail = 0;

  hz_ctrl #(.REG_AW(AW)) u_dut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rs1_used(id_rs1_used),
    .id_rs2_used(id_rs2_used), .id_is_store(id_is_store),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .idex_rd(idex_rd), .idex_we(idex_we), .idex_mem_rd(idex_mem_rd),
    .exmem_rd(exmem_rd), .exmem_we(exmem_we), .exmem_mem_rd(exmem_mem_rd),
    .exmem_is_store(exmem_is_store), .exmem_rs2(exmem_rs2),
    .memwb_rd(memwb_rd), .memwb_we(memwb_we), .memwb_mem_rd(memwb_mem_rd),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .st_data_fwd(st_data_fwd),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
  );

  function automatic logic [1:0] exp_sel(logic [AW-1:0] s);
    if (exmem_we && !exmem_mem_rd && exmem_rd != 0 && exmem_rd == s) return 2'b10;
    if (memwb_we && memwb_rd != 0 && memwb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic exp_stall();
    logic ld;
    ld = idex_mem_rd && idex_we && idex_rd != 0;
    return ld && ((id_rs1_used && id_rs1 == idex_rd) ||
                  (id_rs2_used && id_rs2 == idex_rd && !id_is_store));
  endfunction

  function automatic logic exp_stfwd();
    return exmem_is_store && memwb_we && memwb_mem_rd && memwb_rd != 0 &&
           memwb_rd == exmem_rs2;
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; idex_rd = 0; exmem_rd = 0;
    exmem_rs2 = 0; memwb_rd = 0; id_rs1_used = 0; id_rs2_used = 0; id_is_store = 0;
    idex_we = 0; idex_mem_rd = 0; exmem_we = 0; exmem_mem_rd = 0;
    exmem_is_store = 0; memwb_we = 0; memwb_mem_rd = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic full_check(string req);
    chk(req, {2'b0, fwd_a}, {2'b0, exp_sel(ex_rs1)});
    chk(req, {2'b0, fwd_b}, {2'b0, exp_sel(ex_rs2)});
    chk(req, {1'b0, pc_hold, ifid_hold, idex_bubble}, {1'b0, {3{exp_stall()}}});
    chk(req, {3'b0, st_data_fwd}, {3'b0, exp_stfwd()});
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    settle();
    chk("R4 idle", {fwd_a, fwd_b}, 4'h0);
    chk("R10 idle", {1'b0, pc_hold, ifid_hold, idex_bubble}, 4'h0);

    // R1 one ahead
    clear_all(); exmem_we = 1; exmem_rd = 5'd7; ex_rs1 = 5'd7; settle();
    chk("R1", {2'b0, fwd_a}, 4'h2);
    // R2 two ahead, operand B
    clear_all(); memwb_we = 1; memwb_rd = 5'd9; ex_rs2 = 5'd9; settle();
    chk("R2", {2'b0, fwd_b}, 4'h1);
    // R3 both match
    clear_all(); exmem_we = 1; memwb_we = 1; exmem_rd = 5'd3; memwb_rd = 5'd3;
    ex_rs1 = 5'd3; ex_rs2 = 5'd3; settle();
    chk("R3", {fwd_a, fwd_b}, 4'hA);
    // R5 register 0
    clear_all(); exmem_we = 1; memwb_we = 1; idex_we = 1; idex_mem_rd = 1;
    id_rs1_used = 1; settle();
    chk("R5", {fwd_a, fwd_b}, 4'h0);
    chk("R5 stall", {3'b0, pc_hold}, 4'h0);
    // R6 write disabled
    clear_all(); exmem_rd = 5'd4; memwb_rd = 5'd4; ex_rs1 = 5'd4; idex_rd = 5'd4;
    idex_mem_rd = 1; id_rs1 = 5'd4; id_rs1_used = 1; settle();
    chk("R6", {2'b0, fwd_a}, 4'h0);
    chk("R6 stall", {3'b0, idex_bubble}, 4'h0);
    // R7 load-use
    clear_all(); idex_we = 1; idex_mem_rd = 1; idex_rd = 5'd12; id_rs2 = 5'd12;
    id_rs2_used = 1; settle();
    chk("R7", {1'b0, pc_hold, ifid_hold, idex_bubble}, 4'h7);
    // R8 store data only: no stall; address: stall
    id_is_store = 1; settle();
    chk("R8 data", {3'b0, pc_hold}, 4'h0);
    id_rs1 = 5'd12; id_rs1_used = 1; settle();
    chk("R8 addr", {3'b0, pc_hold}, 4'h1);
    // R11 unused source
    id_rs1_used = 0; id_rs2_used = 0; id_is_store = 0; settle();
    chk("R11", {3'b0, ifid_hold}, 4'h0);
    // R9 store copy
    clear_all(); exmem_is_store = 1; exmem_rs2 = 5'd20; memwb_we = 1;
    memwb_mem_rd = 1; memwb_rd = 5'd20; settle();
    chk("R9", {3'b0, st_data_fwd}, 4'h1);
    memwb_mem_rd = 0; settle();
    chk("R9 non-load", {3'b0, st_data_fwd}, 4'h0);
    // R12 load in memory stage, older writer present
    clear_all(); exmem_we = 1; exmem_mem_rd = 1; exmem_rd = 5'd6; ex_rs2 = 5'd6;
    settle();
    chk("R12 none", {2'b0, fwd_b}, 4'h0);
    memwb_we = 1; memwb_rd = 5'd6; settle();
    chk("R12 older", {2'b0, fwd_b}, 4'h1);

    // random from a narrow register pool
    for (int i = 0; i < 400; i++) begin
      @(posedge clk);
      id_rs1 = 5'($urandom_range(3, 0)); id_rs2 = 5'($urandom_range(3, 0));
      ex_rs1 = 5'($urandom_range(3, 0)); ex_rs2 = 5'($urandom_range(3, 0));
      idex_rd = 5'($urandom_range(3, 0)); exmem_rd = 5'($urandom_range(3, 0));
      exmem_rs2 = 5'($urandom_range(3, 0)); memwb_rd = 5'($urandom_range(3, 0));
      {id_rs1_used, id_rs2_used, id_is_store, idex_we, idex_mem_rd} = 5'($urandom);
      {exmem_we, exmem_mem_rd, exmem_is_store, memwb_we, memwb_mem_rd} = 5'($urandom);
      settle();
      full_check("R1 R2 R3 R7 R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule